// File: doc/BRIEF.md
# Clock Controller Register File

This block holds the software-visible state of a system clock controller: PLL control words, bus divider settings, peripheral clock words and DRAM clock settings. It generates no clocks. It only keeps 32-bit words that software reads and writes over a simple word-wide bus. The bus has an address, a write enable with write data, and a read enable with registered read data.

Some writes are changed before they are stored. A PLL that software enables is stored with its lock flag already set. The two update-request strobes are never stored as set. The implemented window ends at byte offset 0x324. Past that point, reads give zero, writes are dropped, and a one-cycle error pulse marks the access.

Top module: `ccu_regfile`

## Requirements
- R1: In the cycle after synchronous reset is released, these words read back as follows:
  - 0x000 = 0x00001000
  - 0x008 = 0x00035514
  - 0x010, 0x018, 0x030, 0x038 and 0x048 = 0x03006207
  - 0x020 = 0x00001000
  - 0x028 and 0x02C = 0x00041811
  - 0x034 = 0x00001811
  - 0x040 = 0x00000515
  - 0x04C = 0x00001800
  - 0x054 = 0x00001010
  - 0x058 = 0x01000000
  - 0x0F0 = 0x00000001
  - 0x0F8 = 0x0CCCA000
  - 0x310 = 0x0000000F
- R2: After reset, every other word below offset 0x324 reads zero.
- R3: The PLL words are at offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x02C, 0x030, 0x034, 0x038, 0x040, 0x048 and 0x04C. A write to one of them with bit 31 (enable) set stores bit 28 (lock) as 1.
- R4: A write to a PLL word with bit 31 clear stores bit 28 exactly as it appears in the write data.
- R5: A write to offset 0x04C stores bit 30 as 0, and the rule of R3 still applies.
- R6: A write to offset 0x0F4 stores bit 16 as 0.
- R7: A write to any other offset below 0x324 is stored unchanged, including bits 16, 28, 30 and 31.
- R8: A read at any offset from 0x324 to the top of the address space returns zero.
- R9: A write at an offset of 0x324 or above changes no stored word.
- R10: `busErr` is high for exactly the one cycle that follows a read or write at an offset of 0x324 or above. It stays low after in-window accesses.
- R11: `busRdData` takes new data on the clock edge at which `busRdEn` is sampled high. It holds its value while `busRdEn` is low, and it is zero during reset.
- R12: Address bits [1:0] do not select a word: the word index is the byte offset divided by four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | ADDR_W (12) | Byte offset of the access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle pulse for an out-of-window access |

## Verification
Three results are due at the first clock edge after the access is sampled:
- a write is stored, with its adjustments, at that edge;
- read data is loaded at that edge;
- the error pulse is registered at that edge.

The bench drives all inputs on the falling edge and samples on the next falling edge, half a cycle after the edge that updates them. A written value is checked by a separate read one cycle later. The error pulse is sampled once on the falling edge after the access, and again one cycle later to confirm it has fallen.

// File: rtl/ccu_regfile_pkg.sv
package ccu_regfile_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned WIN_LIMIT = 'h324;
  localparam int unsigned REG_WORDS = WIN_LIMIT / 4;
  localparam int unsigned IDX_W     = $clog2(REG_WORDS);

  localparam int unsigned PLL_EN_BIT   = 31;
  localparam int unsigned PLL_LOCK_BIT = 28;
  localparam int unsigned DDR1_UPD_BIT = 30;
  localparam int unsigned DRAM_UPD_BIT = 16;

  localparam int unsigned DDR1_IDX     = 'h04C / 4;
  localparam int unsigned DRAM_CFG_IDX = 'h0F4 / 4;

  typedef logic [IDX_W-1:0]  regIdx_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    logic store;
    logic load;
    logic zeroRd;
    logic fault;
    logic lockRule;
    logic clrDdrUpd;
    logic clrDramUpd;
  } strobes_t;

  function automatic logic isPllIdx(input regIdx_t i);
    case (int'(i))
      'h00, 'h02, 'h04, 'h06, 'h08, 'h0A, 'h0B,
      'h0C, 'h0D, 'h0E, 'h10, 'h12, 'h13: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic word_t resetWord(input int unsigned i);
    case (i)
      'h00, 'h08:                   return 32'h0000_1000;
      'h02:                         return 32'h0003_5514;
      'h04, 'h06, 'h0C, 'h0E, 'h12: return 32'h0300_6207;
      'h0A, 'h0B:                   return 32'h0004_1811;
      'h0D:                         return 32'h0000_1811;
      'h10:                         return 32'h0000_0515;
      'h13:                         return 32'h0000_1800;
      'h15:                         return 32'h0000_1010;
      'h16:                         return 32'h0100_0000;
      'h3C:                         return 32'h0000_0001;
      'h3E:                         return 32'h0CCC_A000;
      'hC4:                         return 32'h0000_000F;
      default:                      return '0;
    endcase
  endfunction

endpackage

// File: rtl/ccu_regfile_ctrl.sv
module ccu_regfile_ctrl
  import ccu_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobes_t          stb,
  output regIdx_t           idx
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WIN_LIMIT);

  logic inWin;

  always_comb begin
    inWin = (busAddr < LIMIT);
    idx   = busAddr[IDX_W+1:2];

    stb            = '0;
    stb.store      = busWrEn & inWin;
    stb.load       = busRdEn;
    stb.zeroRd     = ~inWin;
    stb.fault      = (busWrEn | busRdEn) & ~inWin;
    stb.lockRule   = isPllIdx(idx);
    stb.clrDdrUpd  = (int'(idx) == DDR1_IDX);
    stb.clrDramUpd = (int'(idx) == DRAM_CFG_IDX);
  end

endmodule

// File: rtl/ccu_regfile_dp.sv
module ccu_regfile_dp
  import ccu_regfile_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  strobes_t stb,
  input  regIdx_t  idx,
  input  word_t    wrData,
  output word_t    rdData,
  output logic     errPulse
);

  word_t mem [REG_WORDS];
  word_t adjWord;

  always_comb begin
    adjWord = wrData;
    if (stb.clrDdrUpd)  adjWord[DDR1_UPD_BIT] = 1'b0;
    if (stb.clrDramUpd) adjWord[DRAM_UPD_BIT] = 1'b0;
    if (stb.lockRule && wrData[PLL_EN_BIT]) adjWord[PLL_LOCK_BIT] = 1'b1;
  end

  for (genvar g = 0; g < REG_WORDS; g++) begin : gWord
    localparam word_t RST_VAL = resetWord(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= RST_VAL;
      end else if (stb.store && (int'(idx) == g)) begin
        mem[g] <= adjWord;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData   <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= stb.fault;
      if (stb.load) begin
        rdData <= stb.zeroRd ? '0 : mem[idx];
      end
    end
  end

endmodule

// File: rtl/ccu_regfile.sv
module ccu_regfile
  import ccu_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic              busErr
);

  strobes_t stb;
  regIdx_t  idx;

  ccu_regfile_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .stb     (stb),
    .idx     (idx)
  );

  ccu_regfile_dp uDp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .idx      (idx),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .errPulse (busErr)
  );

endmodule

// File: rtl/ccu_regfile_chk.sv
module ccu_regfile_chk
  import ccu_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [31:0]       busRdData,
  input logic              busErr
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WIN_LIMIT);

  logic outAcc;
  logic rdDdr1;
  logic rdDram;
  logic rdPll;

  always_comb begin
    outAcc = (busRdEn || busWrEn) && (busAddr >= LIMIT);
    rdDdr1 = busRdEn && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(DDR1_IDX));
    rdDram = busRdEn && (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(DRAM_CFG_IDX));
    rdPll  = busRdEn && (busAddr < LIMIT) && isPllIdx(busAddr[IDX_W+1:2]);
  end

  a_r8_zero_read: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && busAddr >= LIMIT) |=> (busRdData == 32'h0));

  a_r10_err_set: assert property (@(posedge clk) disable iff (rst)
    outAcc |=> busErr);

  a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
    !outAcc |=> !busErr);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !busRdEn |=> $stable(busRdData));

  a_r5_ddr1_upd: assert property (@(posedge clk) disable iff (rst)
    rdDdr1 |=> !busRdData[DDR1_UPD_BIT]);

  a_r6_dram_upd: assert property (@(posedge clk) disable iff (rst)
    rdDram |=> !busRdData[DRAM_UPD_BIT]);

  a_r3_lock: assert property (@(posedge clk) disable iff (rst)
    rdPll |=> (!busRdData[PLL_EN_BIT] || busRdData[PLL_LOCK_BIT]));

endmodule

bind ccu_regfile ccu_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .busErr    (busErr)
);

// File: tb/sim_ccu_regfile.sv
`timescale 1ns/1ps
module sim_ccu_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        busErr;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  ccu_regfile u0 (
    .clk       (clk),
    .rst       (rst),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .busRdData (busRdData),
    .busErr    (busErr)
  );

  // {offset, write data, expected readback}
  localparam int NV = 13;
  localparam logic [75:0] VECS [NV] = '{
    {12'h000, 32'h8000_0000, 32'h9000_0000},  // R3
    {12'h010, 32'h8000_0207, 32'h9000_0207},  // R3
    {12'h04C, 32'hC000_0000, 32'h9000_0000},  // R5
    {12'h04C, 32'h4000_1234, 32'h0000_1234},  // R5
    {12'h038, 32'h1000_0005, 32'h1000_0005},  // R4
    {12'h048, 32'h0000_0000, 32'h0000_0000},  // R4
    {12'h0F4, 32'hFFFF_FFFF, 32'hFFFE_FFFF},  // R6
    {12'h0F4, 32'h0001_0001, 32'h0000_0001},  // R6
    {12'h004, 32'h8000_0000, 32'h8000_0000},  // R7
    {12'h054, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R7
    {12'h0F8, 32'h4000_0000, 32'h4000_0000},  // R7
    {12'h320, 32'h1234_5678, 32'h1234_5678},  // R7
    {12'h0F0, 32'h8001_0000, 32'h8001_0000}   // R7
  };

  function automatic string vecTag(input int i);
    case (i)
      0, 1:    return "R3";
      2, 3:    return "R5";
      4, 5:    return "R4";
      6, 7:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [11:0] a, input logic [31:0] exp);
    doRead(a);
    check(tag, busRdData, exp);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset state of outputs (R11, R10)
    repeat (3) @(negedge clk);
    check("R11", busRdData, 32'h0);
    check("R10", {31'h0, busErr}, 32'h0);
    rst = 1'b0;

    // R1 reset values
    readCheck("R1", 12'h000, 32'h0000_1000);
    readCheck("R1", 12'h008, 32'h0003_5514);
    readCheck("R1", 12'h018, 32'h0300_6207);
    readCheck("R1", 12'h048, 32'h0300_6207);
    readCheck("R1", 12'h020, 32'h0000_1000);
    readCheck("R1", 12'h02C, 32'h0004_1811);
    readCheck("R1", 12'h034, 32'h0000_1811);
    readCheck("R1", 12'h040, 32'h0000_0515);
    readCheck("R1", 12'h04C, 32'h0000_1800);
    readCheck("R1", 12'h054, 32'h0000_1010);
    readCheck("R1", 12'h058, 32'h0100_0000);
    readCheck("R1", 12'h0F0, 32'h0000_0001);
    readCheck("R1", 12'h0F8, 32'h0CCC_A000);
    readCheck("R1", 12'h310, 32'h0000_000F);
    // R2 zero words
    readCheck("R2", 12'h004, 32'h0);
    readCheck("R2", 12'h0F4, 32'h0);
    readCheck("R2", 12'h100, 32'h0);
    readCheck("R2", 12'h31C, 32'h0);

    // vector table: write then read back
    for (int i = 0; i < NV; i++) begin
      doWrite(VECS[i][75:64], VECS[i][63:32]);
      readCheck(vecTag(i), VECS[i][75:64], VECS[i][31:0]);
    end

    // R8 out-of-window reads
    readCheck("R8", 12'h324, 32'h0);
    readCheck("R8", 12'hFFC, 32'h0);

    // R9 out-of-window writes change nothing
    doWrite(12'h800, 32'hFFFF_FFFF);
    readCheck("R9", 12'h000, 32'h9000_0000);
    doWrite(12'h324, 32'hA5A5_A5A5);
    readCheck("R9", 12'h324, 32'h0);
    doWrite(12'hB10, 32'h5555_5555);
    readCheck("R9", 12'h310, 32'h0000_000F);

    // R10 error pulse
    doRead(12'h400);
    check("R10", {31'h0, busErr}, 32'h1);
    @(negedge clk);
    check("R10", {31'h0, busErr}, 32'h0);
    doWrite(12'hC00, 32'h1);
    check("R10", {31'h0, busErr}, 32'h1);
    @(negedge clk);
    check("R10", {31'h0, busErr}, 32'h0);
    doRead(12'h320);
    check("R10", {31'h0, busErr}, 32'h0);

    // R11 hold while read enable low
    readCheck("R11", 12'h054, 32'hDEAD_BEEF);
    @(negedge clk);
    busAddr = 12'h000;
    busWrData = 32'h0;
    @(negedge clk);
    check("R11", busRdData, 32'hDEAD_BEEF);

    // R12 low address bits ignored
    readCheck("R12", 12'h056, 32'hDEAD_BEEF);
    doWrite(12'h0F3, 32'h0000_00AA);
    readCheck("R12", 12'h0F0, 32'h0000_00AA);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule